// File: doc/BRIEF.md
# Byte-FIFO SPI Master with Status and Interrupt

This block is a bus-controlled SPI master. Software pushes bytes into a 64-entry transmit FIFO through a data port, and a shift engine clocks them out most-significant bit first. Each byte that goes out brings one byte back from the slave, and that byte lands in a 64-entry receive FIFO, which software drains through the same port. To read from a slave, software sends zero filler bytes. Clock polarity, clock phase and the SCLK rate can all be programmed.

A status word reports both FIFO levels, a transmit-idle flag and two ready flags. Each ready flag compares a FIFO level with a programmable threshold. Four sticky error flags record misuse at either end of the FIFOs, and a write-one-to-clear register resets them. A single interrupt line is the OR of the conditions that software has enabled.

The chip-select output runs in one of two modes. In manual mode it follows a register bit. In automatic mode it frames each burst of back-to-back bytes. A soft-reset bit empties the datapath and leaves the configuration as it was.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the status word reads 0x02000001 (idle, empty, TX ready). csN is 1, sclk is 0 and irq is 0. The chip-select register reads 1.
- R2: Bytes written at address 6 are shifted out on mosi MSB first, and only while channel bit 0 (TX enable) is 1. The SCLK period is 2*(div+1) system clocks, where div is the value in address 7. Status bit 25 is 1 exactly when the TX FIFO is empty and the shifter is idle.
- R3: Channel bit 3 sets the idle level of sclk. Channel bit 2 = 0 samples on the leading edge and changes mosi on the trailing edge; bit 2 = 1 does the opposite.
- R4: Each finished byte pushes the sampled miso byte into the RX FIFO when channel bit 1 (RX enable) is 1. Reads at address 6 return the received bytes in arrival order.
- R5: Status bits 23:15 hold the RX level and bits 14:6 hold the TX level. Each FIFO holds 64 bytes.
- R6: Status bit 0 is 1 when TX level <= the TX threshold (address 1, bits 10:5). Status bit 1 is 1 when RX level is non-zero and >= the RX threshold (address 1, bits 16:11).
- R7: A data write while the TX FIFO is full discards the byte and sets status bit 3.
- R8: A data read while the RX FIFO is empty returns 0 and sets status bit 4.
- R9: A byte received while the RX FIFO is full is dropped and sets status bit 5.
- R10: If a byte finishes while manual chip select is held low and the TX FIFO is empty, status bit 2 is set. Automatic mode never sets it.
- R11: Writing 1 at address 5 clears the error flags: bit 1 clears RX overrun, bit 2 RX underrun, bit 3 TX overrun and bit 4 TX underrun. Bits written as 0 leave their flags unchanged.
- R12: While channel bit 5 is 1, both FIFOs are empty, the shifter is idle, data writes are ignored and the error flags read 0. Configuration registers keep their values.
- R13: With chip-select bit 1 = 0, csN follows chip-select bit 0. With bit 1 = 1, csN goes low before the first SCLK edge of a burst, stays low through it, and returns high once the TX FIFO is empty and the last byte is done.
- R14: irq is 1 when any condition is both true and enabled at address 3. The enable bits are: bit 0 TX ready, bit 1 RX ready, bit 2 TX underrun, bit 3 TX overrun, bit 4 RX underrun, bit 5 RX overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during the access cycle |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 1 | Active-low chip select |

## Verification
The bench wires miso back to mosi and decodes mosi on its own at the sample edges of each mode. A design that shifts LSB first, or that samples on the wrong edge, therefore shows up both at the pins and in the bytes read back. The full-FIFO cases are driven on purpose: 65 writes into a stopped transmitter, then one extra byte into a full receiver. A FIFO with an off-by-one limit, or one that lets a discarded byte through, returns a wrong sequence or wrong flags. Clearing error flags one bit at a time catches a decoder that clears too many flags. The soft-reset case checks that configuration survives while the datapath does not. The automatic chip-select case fails any design that moves SCLK while select is high.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
  localparam int DIV_W      = 8;
  localparam int TRIG_W     = 6;
  localparam int ADDR_W     = 3;

  localparam logic [ADDR_W-1:0] ADR_CHAN  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_TRIG  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CS    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_IRQEN = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_DATA  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_DIV   = 3'd7;

  typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_LAST} shState_t;

  // strobes and configuration from control to datapath
  typedef struct packed {
    logic             txPush;
    logic [7:0]       txByte;
    logic             rxPop;
    logic             flush;
    logic             txOn;
    logic             rxOn;
    logic             cpol;
    logic             cpha;
    logic             csAuto;
    logic             csLevel;
    logic [DIV_W-1:0] div;
  } ctlStrb_t;

  // state and events from datapath to control
  typedef struct packed {
    logic [LVL_W-1:0] txLevel;
    logic [LVL_W-1:0] rxLevel;
    logic             txFull;
    logic             txEmpty;
    logic             rxFull;
    logic             rxEmpty;
    logic [7:0]       rxHead;
    logic             txDone;
    logic             rxOverEvt;
    logic             txUnderEvt;
  } dpStat_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           headData,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign level    = count;
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);

  // R7: control must never push into a full FIFO
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  // R8: control must never pop an empty FIFO
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_fifo_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  ctlStrb_t ctl,
  input  logic     miso,
  output dpStat_t  stat,
  output logic     sclk,
  output logic     mosi,
  output logic     csN
);
  logic [7:0]       txHead, rxHead;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic             txFull, txEmpty, rxFull, rxEmpty;
  logic             txPop, rxPush;

  shState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [3:0]       edgeCnt;
  logic             sclkQ;
  logic [7:0]       txShift, rxShift;
  logic             tick, sampleEdge, canLoad, finishing;

  spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .flush(ctl.flush),
    .push(ctl.txPush), .pushData(ctl.txByte), .pop(txPop),
    .headData(txHead), .level(txLevel), .full(txFull), .empty(txEmpty));

  spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .flush(ctl.flush),
    .push(rxPush), .pushData(rxShift), .pop(ctl.rxPop),
    .headData(rxHead), .level(rxLevel), .full(rxFull), .empty(rxEmpty));

  assign tick       = (state == SH_RUN) && (divCnt == ctl.div);
  assign sampleEdge = (edgeCnt[0] == ctl.cpha);
  assign canLoad    = (state != SH_RUN) && ctl.txOn && !txEmpty && !ctl.flush;
  assign txPop      = canLoad;
  assign finishing  = (state == SH_LAST) && !ctl.flush;
  assign rxPush     = finishing && ctl.rxOn && !rxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SH_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      sclkQ   <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
    end else if (ctl.flush) begin
      state   <= SH_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      sclkQ   <= ctl.cpol;
    end else begin
      case (state)
        SH_IDLE, SH_LAST: begin
          sclkQ <= ctl.cpol;
          if (canLoad) begin
            txShift <= txHead;
            state   <= SH_RUN;
            divCnt  <= '0;
            edgeCnt <= '0;
          end else begin
            state <= SH_IDLE;
          end
        end
        SH_RUN: begin
          if (tick) begin
            divCnt  <= '0;
            sclkQ   <= ~sclkQ;
            edgeCnt <= edgeCnt + 1'b1;
            if (sampleEdge)
              rxShift <= {rxShift[6:0], miso};
            else if (edgeCnt != 4'd0)
              txShift <= {txShift[6:0], 1'b0};
            if (edgeCnt == 4'd15) state <= SH_LAST;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign sclk = sclkQ;
  assign mosi = txShift[7];
  assign csN  = ctl.csAuto ? (state == SH_IDLE) : ctl.csLevel;

  always_comb begin
    stat            = '0;
    stat.txLevel    = txLevel;
    stat.rxLevel    = rxLevel;
    stat.txFull     = txFull;
    stat.txEmpty    = txEmpty;
    stat.rxFull     = rxFull;
    stat.rxEmpty    = rxEmpty;
    stat.rxHead     = rxHead;
    stat.txDone     = txEmpty && (state == SH_IDLE);
    stat.rxOverEvt  = finishing && ctl.rxOn && rxFull;
    stat.txUnderEvt = finishing && !ctl.csAuto && !ctl.csLevel && txEmpty;
  end

  // R13: in automatic mode the clock never leaves idle while select is high
  a_r13_auto_cs_frame: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.csAuto && $stable(ctl.cpol) && (sclk != ctl.cpol)) |-> !csN);
  // R2: an idle transmitter parks the clock at its idle level
  a_r2_done_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stat.txDone && $stable(ctl.cpol)) |-> (sclk == ctl.cpol));
endmodule

// File: rtl/spi_reg_ctl.sv
module spi_reg_ctl
  import spi_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  input  dpStat_t           stat,
  output ctlStrb_t          ctl
);
  logic              txOn, rxOn, cpha, cpol, swRst;
  logic [TRIG_W-1:0] txTrig, rxTrig;
  logic              csAuto, csLevel;
  logic [5:0]        irqEn;
  logic [DIV_W-1:0]  div;
  logic              errTxUnder, errTxOver, errRxUnder, errRxOver;

  logic wrStb, rdStb, clrWr;
  logic txPushOk, txOverEvt, rxPopOk, rxUnderEvt;
  logic txRdy, rxRdy;
  logic [5:0] cond;

  assign wrStb      = busSel && busWe;
  assign rdStb      = busSel && !busWe;
  assign clrWr      = wrStb && (busAddr == ADR_CLR);
  assign txPushOk   = wrStb && (busAddr == ADR_DATA) && !swRst && !stat.txFull;
  assign txOverEvt  = wrStb && (busAddr == ADR_DATA) && !swRst && stat.txFull;
  assign rxPopOk    = rdStb && (busAddr == ADR_DATA) && !swRst && !stat.rxEmpty;
  assign rxUnderEvt = rdStb && (busAddr == ADR_DATA) && !swRst && stat.rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {txOn, rxOn, cpha, cpol, swRst} <= '0;
      txTrig  <= '0;
      rxTrig  <= '0;
      csAuto  <= 1'b0;
      csLevel <= 1'b1;
      irqEn   <= '0;
      div     <= '0;
    end else if (wrStb) begin
      case (busAddr)
        ADR_CHAN: begin
          txOn  <= busWdata[0];
          rxOn  <= busWdata[1];
          cpha  <= busWdata[2];
          cpol  <= busWdata[3];
          swRst <= busWdata[5];
        end
        ADR_TRIG: begin
          txTrig <= busWdata[5 +: TRIG_W];
          rxTrig <= busWdata[11 +: TRIG_W];
        end
        ADR_CS: begin
          csLevel <= busWdata[0];
          csAuto  <= busWdata[1];
        end
        ADR_IRQEN: irqEn <= busWdata[5:0];
        ADR_DIV:   div   <= busWdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // sticky errors: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {errTxUnder, errTxOver, errRxUnder, errRxOver} <= '0;
    end else if (swRst) begin
      {errTxUnder, errTxOver, errRxUnder, errRxOver} <= '0;
    end else begin
      errRxOver  <= (errRxOver  && !(clrWr && busWdata[1])) || stat.rxOverEvt;
      errRxUnder <= (errRxUnder && !(clrWr && busWdata[2])) || rxUnderEvt;
      errTxOver  <= (errTxOver  && !(clrWr && busWdata[3])) || txOverEvt;
      errTxUnder <= (errTxUnder && !(clrWr && busWdata[4])) || stat.txUnderEvt;
    end
  end

  assign txRdy = (stat.txLevel <= LVL_W'(txTrig));
  assign rxRdy = !stat.rxEmpty && (stat.rxLevel >= LVL_W'(rxTrig));
  assign cond  = {errRxOver, errRxUnder, errTxOver, errTxUnder, rxRdy, txRdy};
  assign irq   = |(irqEn & cond);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADR_CHAN:  busRdata[5:0] = {swRst, 1'b0, cpol, cpha, rxOn, txOn};
      ADR_TRIG: begin
        busRdata[5 +: TRIG_W]  = txTrig;
        busRdata[11 +: TRIG_W] = rxTrig;
      end
      ADR_CS:    busRdata[1:0] = {csAuto, csLevel};
      ADR_IRQEN: busRdata[5:0] = irqEn;
      ADR_STAT: begin
        busRdata[25]    = stat.txDone;
        busRdata[23:15] = 9'(stat.rxLevel);
        busRdata[14:6]  = 9'(stat.txLevel);
        busRdata[5:0]   = cond;
      end
      ADR_DATA:  busRdata[7:0] = stat.rxEmpty ? 8'h00 : stat.rxHead;
      ADR_DIV:   busRdata[DIV_W-1:0] = div;
      default: ;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.txPush  = txPushOk;
    ctl.txByte  = busWdata[7:0];
    ctl.rxPop   = rxPopOk;
    ctl.flush   = swRst;
    ctl.txOn    = txOn;
    ctl.rxOn    = rxOn;
    ctl.cpol    = cpol;
    ctl.cpha    = cpha;
    ctl.csAuto  = csAuto;
    ctl.csLevel = csLevel;
    ctl.div     = div;
  end

  // R8: an empty read leaves the underrun flag set
  a_r8_underrun_sticks: assert property (@(posedge clk) disable iff (!rstN)
    rxUnderEvt |=> errRxUnder);
  // R11: a clear with no competing event removes the flag
  a_r11_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && busWdata[2] && !rxUnderEvt) |=> !errRxUnder);
  // R12: soft reset empties both FIFOs
  a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    swRst |=> (stat.txLevel == '0 && stat.rxLevel == '0));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWe,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        csN
);
  ctlStrb_t ctl;
  dpStat_t  stat;

  spi_reg_ctl i_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .stat(stat), .ctl(ctl));

  spi_shift_dp i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .miso(miso),
    .stat(stat), .sclk(sclk), .mosi(mosi), .csN(csN));
endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  import spi_fifo_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irq, sclk, mosi, miso, csN;

  int checks = 0, errCnt = 0, cyc = 0;

  // monitor state
  logic monOn = 1'b0, monCpol = 1'b0, monCpha = 1'b0, prevSclk = 1'b0, monLead;
  logic [7:0] monShift = '0;
  logic [7:0] monQ [128];
  int monBits = 0, monCnt = 0, csViol = 0, lastLead = 0, lastPeriod = 0;

  assign miso = mosi;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .csN(csN));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (monOn && (sclk !== prevSclk)) begin
      if (csN !== 1'b0) csViol++;
      monLead = (prevSclk === monCpol);
      if (monLead) begin
        lastPeriod = cyc - lastLead;
        lastLead   = cyc;
      end
      if (monLead == !monCpha) begin
        monShift = {monShift[6:0], mosi};
        monBits++;
        if (monBits == 8) begin
          monQ[monCnt % 128] = monShift;
          monCnt++;
          monBits = 0;
        end
      end
    end
    prevSclk = sclk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    int n = 0;
    do begin
      rdReg(ADR_STAT, s);
      n++;
    end while (!s[25] && n < 20000);
    if (!s[25]) chk("R2 transmit never finished", s, 32'h0200_0000);
    repeat (2) @(negedge clk);
  endtask

  task automatic setMode(input logic pol, input logic pha, input logic [1:0] en);
    monOn = 1'b0;
    wr(ADR_CHAN, 32'(en) | (32'(pha) << 2) | (32'(pol) << 3));
    repeat (3) @(posedge clk);
    monBits = 0; monCnt = 0; monCpol = pol; monCpha = pha;
    monOn = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rdReg(ADR_STAT, d);
    chk("R1 status after reset", d, 32'h0200_0001);
    rdReg(ADR_CS, d);
    chk("R1 cs register after reset", d, 32'h1);
    chk("R1 csN after reset", 32'(csN), 1);
    chk("R1 sclk after reset", 32'(sclk), 0);
    chk("R1 irq after reset", 32'(irq), 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(ADR_DIV, 1);
    wr(ADR_CS, 0);
    chk("R13 manual csN low", 32'(csN), 0);
    setMode(1'b0, 1'b0, 2'b10);
    wr(ADR_DATA, 32'hA5);
    wr(ADR_DATA, 32'h3C);
    repeat (40) @(negedge clk);
    rdReg(ADR_STAT, d);
    chk("R2 tx held while disabled: level", 32'(d[14:6]), 2);
    chk("R2 tx held while disabled: done", 32'(d[25]), 0);
    chk("R2 no bits while disabled", monCnt, 0);
    setMode(1'b0, 1'b0, 2'b11);
    waitDone();
    chk("R2 bytes sent", monCnt, 2);
    chk("R2 first byte MSB first", 32'(monQ[0]), 32'hA5);
    chk("R2 second byte", 32'(monQ[1]), 32'h3C);
    chk("R2 sclk period", lastPeriod, 4);
    rdReg(ADR_STAT, d);
    chk("R5 rx level field", 32'(d[23:15]), 2);
    chk("R10 tx underrun in manual frame", 32'(d[2]), 1);
    rdReg(ADR_DATA, d);
    chk("R4 rx first", d, 32'hA5);
    rdReg(ADR_DATA, d);
    chk("R4 rx second", d, 32'h3C);
    wr(ADR_CS, 1);
    chk("R13 manual csN high", 32'(csN), 1);
    wr(ADR_CLR, 32'h10);
    rdReg(ADR_STAT, d);
    chk("R11 tx underrun cleared", 32'(d[2]), 0);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    for (int m = 1; m < 4; m++) begin
      logic [7:0] b;
      b = 8'h69 + 8'(m * 17);
      setMode(m[1], m[0], 2'b11);
      wr(ADR_DATA, 32'(b));
      waitDone();
      chk($sformatf("R3 mode %0d sclk idle", m), 32'(sclk), 32'(m[1]));
      chk($sformatf("R3 mode %0d mosi byte", m), 32'(monQ[0]), 32'(b));
      rdReg(ADR_DATA, d);
      chk($sformatf("R3 mode %0d loopback byte", m), d, 32'(b));
    end
    setMode(1'b0, 1'b0, 2'b11);
  endtask

  task automatic t_autoCs();
    logic [31:0] d;
    wr(ADR_CS, 2);
    chk("R13 auto csN idle high", 32'(csN), 1);
    csViol = 0; monCnt = 0;
    wr(ADR_DATA, 32'h11);
    wr(ADR_DATA, 32'h22);
    wr(ADR_DATA, 32'h33);
    repeat (2) @(negedge clk);
    chk("R13 auto csN low in burst", 32'(csN), 0);
    waitDone();
    chk("R13 no edge with select high", csViol, 0);
    chk("R13 auto csN high after burst", 32'(csN), 1);
    chk("R13 burst byte count", monCnt, 3);
    rdReg(ADR_STAT, d);
    chk("R10 no underrun in auto mode", 32'(d[2]), 0);
    for (int i = 0; i < 3; i++) rdReg(ADR_DATA, d);
    wr(ADR_CS, 1);
  endtask

  task automatic t_readyIrq();
    logic [31:0] d;
    wr(ADR_TRIG, (32'd3 << 11) | (32'd2 << 5));
    setMode(1'b0, 1'b0, 2'b10);
    for (int i = 0; i < 3; i++) wr(ADR_DATA, 32'(i + 1));
    rdReg(ADR_STAT, d);
    chk("R6 tx not ready above threshold", 32'(d[0]), 0);
    wr(ADR_IRQEN, 32'h1);
    chk("R14 irq low, tx ready false", 32'(irq), 0);
    setMode(1'b0, 1'b0, 2'b11);
    waitDone();
    rdReg(ADR_STAT, d);
    chk("R6 tx ready when drained", 32'(d[0]), 1);
    chk("R6 rx ready at threshold", 32'(d[1]), 1);
    chk("R14 irq on tx ready", 32'(irq), 1);
    wr(ADR_IRQEN, 32'h2);
    chk("R14 irq on rx ready", 32'(irq), 1);
    rdReg(ADR_DATA, d);
    rdReg(ADR_STAT, d);
    chk("R6 rx ready drops below threshold", 32'(d[1]), 0);
    chk("R14 irq drops with rx ready", 32'(irq), 0);
    wr(ADR_IRQEN, 0);
    rdReg(ADR_DATA, d);
    rdReg(ADR_DATA, d);
    wr(ADR_TRIG, 0);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    wr(ADR_IRQEN, 32'h10);
    rdReg(ADR_DATA, d);
    chk("R8 empty read returns zero", d, 0);
    rdReg(ADR_STAT, d);
    chk("R8 rx underrun set", 32'(d[4]), 1);
    chk("R14 irq on rx underrun", 32'(irq), 1);
    wr(ADR_CLR, 32'h02);
    rdReg(ADR_STAT, d);
    chk("R11 other clear bit leaves underrun", 32'(d[4]), 1);
    wr(ADR_CLR, 32'h04);
    rdReg(ADR_STAT, d);
    chk("R11 underrun cleared", 32'(d[4]), 0);
    chk("R14 irq cleared", 32'(irq), 0);
    wr(ADR_IRQEN, 0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    int bad = 0;
    wr(ADR_DIV, 0);
    setMode(1'b0, 1'b0, 2'b10);
    for (int i = 0; i < 65; i++) wr(ADR_DATA, 32'(i));
    rdReg(ADR_STAT, d);
    chk("R5 tx level full", 32'(d[14:6]), 64);
    chk("R7 tx overrun set", 32'(d[3]), 1);
    setMode(1'b0, 1'b0, 2'b11);
    waitDone();
    rdReg(ADR_STAT, d);
    chk("R5 rx level full", 32'(d[23:15]), 64);
    chk("R9 no rx overrun yet", 32'(d[5]), 0);
    wr(ADR_DATA, 32'hEE);
    waitDone();
    rdReg(ADR_STAT, d);
    chk("R9 rx overrun set", 32'(d[5]), 1);
    chk("R9 rx level stays full", 32'(d[23:15]), 64);
    for (int i = 0; i < 64; i++) begin
      rdReg(ADR_DATA, d);
      if (d !== 32'(i)) bad++;
    end
    chk("R7 R9 received sequence mismatches", bad, 0);
    wr(ADR_CLR, 32'h1E);
    rdReg(ADR_STAT, d);
    chk("R11 all errors cleared", 32'(d[5:2]), 0);
  endtask

  task automatic t_softReset();
    logic [31:0] d;
    setMode(1'b0, 1'b0, 2'b10);
    for (int i = 0; i < 3; i++) wr(ADR_DATA, 32'h40 + 32'(i));
    rdReg(ADR_DATA, d);
    wr(ADR_CHAN, 32'h22);
    rdReg(ADR_STAT, d);
    chk("R12 levels and errors cleared", d & 32'h00FF_FFFC, 0);
    wr(ADR_DATA, 32'h55);
    rdReg(ADR_STAT, d);
    chk("R12 write ignored in reset", 32'(d[14:6]), 0);
    rdReg(ADR_CHAN, d);
    chk("R12 configuration kept", d, 32'h22);
    setMode(1'b0, 1'b0, 2'b11);
    rdReg(ADR_STAT, d);
    chk("R12 status after release", d, 32'h0200_0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_modes();
    t_autoCs();
    t_readyIrq();
    t_underrun();
    t_overrun();
    t_softReset();
    $display("CHECKS %0d ERRORS %0d", checks, errCnt);
    $finish;
  end
endmodule